// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Flags Register

The block performs one arithmetic or logic operation per cycle on two operands, either on their low byte or on the full 16-bit word, chosen by a width input. The result appears combinationally on the result port. At the next rising clock edge the flags register captures six status conditions derived from that result, if the status write enable is high.

The flags register has a fixed 16-bit layout. Three control bits sit in the same register. They change only through a dedicated load port, never through an ALU result. The add-with-carry and subtract-with-borrow operations take their carry-in from the stored carry flag. Operations can therefore be chained across bytes or words by leaving the status write enable asserted.

Top module: `bw_alu`

## Requirements
- R1: Flag positions in `flags_o` are: carry bit 0, parity bit 2, half-carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt-enable bit 9, direction bit 10, overflow bit 11. Bits 1, 3, 5 and 12 to 15 always read 0.
- R2: `op_i` encodes 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 pass B. With `word_i` = 0 only bits 7:0 take part, and `result_o[15:8]` is 0.
- R3: For add and subtract, the carry flag is the carry out of bit 7 (byte) or bit 15 (word); for subtraction it is the borrow. Ops 1 and 3 add or subtract the stored carry flag.
- R4: The parity flag is 1 when `result_o[7:0]` holds an even number of ones, in both widths.
- R5: The half-carry flag is the carry (add) or borrow (subtract) across bit 3 to bit 4.
- R6: The zero flag is 1 when the width-limited result is zero.
- R7: The sign flag copies result bit 7 (byte) or bit 15 (word).
- R8: The overflow flag is 1 when the two's-complement result of an add or subtract does not fit the selected width.
- R9: Ops 4 to 7 clear the carry, half-carry and overflow flags.
- R10: Status flags change only at a clock edge where `flag_we_i` is 1. Otherwise they hold, while `result_o` still follows the inputs.
- R11: Trap, interrupt-enable and direction bits load from `ctrl_i` (bit 0 trap, bit 1 interrupt-enable, bit 2 direction) at an edge with `ctrl_we_i` = 1. ALU operations never alter them.
- R12: While `rst_n` is low, `flags_o` becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| flag_we_i | input | 1 | Status flag update enable |
| ctrl_we_i | input | 1 | Control flag load enable |
| ctrl_i | input | 3 | Control flag values to load |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Flags register |

## Verification
The following properties are checked on every cycle:
- Held status and held control bits when their enables are low.
- The control load path.
- Cleared carry, half-carry and overflow after logic operations.
- Zero and sign flags consistent with the previous result.
- A zero upper byte in byte mode.
- Reserved bits at zero.

Correct carry, borrow, half-carry, overflow and parity values depend on operand values. Only the bench's sweeps can show them. These sweeps cover boundary operands such as 0x7F, 0x80 and 0xFF, both widths and both stored-carry states, and compare against an integer reference model.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  localparam int FLAGS_W = 16;
  localparam int FL_CF = 0;
  localparam int FL_PF = 2;
  localparam int FL_AF = 4;
  localparam int FL_ZF = 6;
  localparam int FL_SF = 7;
  localparam int FL_TF = 8;
  localparam int FL_IF = 9;
  localparam int FL_DF = 10;
  localparam int FL_OF = 11;

  localparam logic [FLAGS_W-1:0] USED_MASK =
    (16'd1 << FL_CF) | (16'd1 << FL_PF) | (16'd1 << FL_AF) |
    (16'd1 << FL_ZF) | (16'd1 << FL_SF) | (16'd1 << FL_TF) |
    (16'd1 << FL_IF) | (16'd1 << FL_DF) | (16'd1 << FL_OF);

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

  // bit 0 trap, bit 1 interrupt enable, bit 2 direction
  typedef struct packed {
    logic df;
    logic ief;
    logic tf;
  } ctrl_t;

  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

  function automatic logic op_is_arith(input alu_op_e op);
    return ~op[2];
  endfunction

  function automatic logic [FLAGS_W-1:0] pack_flags(input stat_t s, input ctrl_t c);
    logic [FLAGS_W-1:0] w;
    w        = '0;
    w[FL_CF] = s.cf;
    w[FL_PF] = s.pf;
    w[FL_AF] = s.af;
    w[FL_ZF] = s.zf;
    w[FL_SF] = s.sf;
    w[FL_OF] = s.of;
    w[FL_TF] = c.tf;
    w[FL_IF] = c.ief;
    w[FL_DF] = c.df;
    return w;
  endfunction

endpackage

// File: rtl/bwalu_adder.sv
module bwalu_adder #(
  parameter int DW = 16
) (
  input  logic          word_i,
  input  logic          sub_i,
  input  logic          cin_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          half_o,
  output logic          ovf_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] wmask;
  logic [DW-1:0] a_m;
  logic [DW-1:0] b_m;
  logic [DW-1:0] b_x;
  logic [DW:0]   tot;
  logic          carry_raw;
  logic          nib_raw;
  logic          a_sgn, b_sgn, r_sgn;

  always_comb begin
    wmask     = word_i ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
    a_m       = a_i & wmask;
    b_m       = b_i & wmask;
    b_x       = sub_i ? (~b_m & wmask) : b_m;
    // subtraction: a + ~b + 1 - borrow_in
    tot       = {1'b0, a_m} + {1'b0, b_x} + {{DW{1'b0}}, (sub_i ^ cin_i)};
    carry_raw = word_i ? tot[DW] : tot[HW];
    nib_raw   = a_m[4] ^ b_x[4] ^ tot[4];
    cy_o      = carry_raw ^ sub_i;
    half_o    = nib_raw ^ sub_i;
    a_sgn     = word_i ? a_m[DW-1] : a_m[HW-1];
    b_sgn     = word_i ? b_x[DW-1] : b_x[HW-1];
    r_sgn     = word_i ? tot[DW-1] : tot[HW-1];
    ovf_o     = (a_sgn == b_sgn) && (r_sgn != a_sgn);
    sum_o     = tot[DW-1:0] & wmask;
  end

endmodule

// File: rtl/bwalu_logic.sv
module bwalu_logic
  import bwalu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic          word_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] raw;

  always_comb begin
    unique case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = b_i;
    endcase
    res_o = word_i ? raw : {{(DW-HW){1'b0}}, raw[HW-1:0]};
  end

endmodule

// File: rtl/bwalu_flagreg.sv
module bwalu_flagreg
  import bwalu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_we_i,
  input  stat_t              st_d_i,
  input  logic               ctrl_we_i,
  input  ctrl_t              ctrl_d_i,
  output logic [FLAGS_W-1:0] flags_o
);
  stat_t st_q;
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (st_we_i)   st_q   <= st_d_i;
      if (ctrl_we_i) ctrl_q <= ctrl_d_i;
    end
  end

  assign flags_o = pack_flags(st_q, ctrl_q);

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~USED_MASK) == '0);  // R1

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !st_we_i) |=> ($stable(flags_o[FL_CF]) && $stable(flags_o[FL_PF]) &&
      $stable(flags_o[FL_AF]) && $stable(flags_o[FL_ZF]) && $stable(flags_o[FL_SF]) &&
      $stable(flags_o[FL_OF])));  // R10

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ctrl_we_i) |=> $stable(flags_o[FL_DF:FL_TF]));  // R11

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_i |=> flags_o[FL_DF:FL_TF] == $past(ctrl_d_i));  // R11

endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bwalu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_i,
  input  logic               word_i,
  input  logic [DW-1:0]      a_i,
  input  logic [DW-1:0]      b_i,
  input  logic               flag_we_i,
  input  logic               ctrl_we_i,
  input  logic [2:0]         ctrl_i,
  output logic [DW-1:0]      result_o,
  output logic [FLAGS_W-1:0] flags_o
);
  localparam int HW = DW / 2;

  alu_op_e       op;
  logic          arith;
  logic          sub_op;
  logic          carry_in;
  logic [DW-1:0] add_sum;
  logic          add_cy;
  logic          add_half;
  logic          add_ovf;
  logic [DW-1:0] log_res;
  stat_t         st_next;
  ctrl_t         ctrl_next;

  assign op        = alu_op_e'(op_i);
  assign arith     = op_is_arith(op);
  assign sub_op    = op_i[1];
  // stored carry feeds ops with carry / borrow in
  assign carry_in  = op_i[0] & flags_o[FL_CF];
  assign ctrl_next = ctrl_t'(ctrl_i);

  bwalu_adder #(.DW(DW)) u_add (
    .word_i (word_i),
    .sub_i  (sub_op),
    .cin_i  (carry_in),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (add_sum),
    .cy_o   (add_cy),
    .half_o (add_half),
    .ovf_o  (add_ovf)
  );

  bwalu_logic #(.DW(DW)) u_log (
    .op_i   (op),
    .word_i (word_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_o  (log_res)
  );

  always_comb begin
    result_o   = arith ? add_sum : log_res;
    st_next.cf = arith & add_cy;
    st_next.af = arith & add_half;
    st_next.of = arith & add_ovf;
    st_next.pf = even_ones(result_o[7:0]);
    st_next.zf = (result_o == '0);
    st_next.sf = word_i ? result_o[DW-1] : result_o[HW-1];
  end

  bwalu_flagreg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_we_i   (flag_we_i),
    .st_d_i    (st_next),
    .ctrl_we_i (ctrl_we_i),
    .ctrl_d_i  (ctrl_next),
    .flags_o   (flags_o)
  );

  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !word_i |-> result_o[DW-1:HW] == '0);  // R2

  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i[2]) |=> (!flags_o[FL_CF] && !flags_o[FL_AF] && !flags_o[FL_OF]));  // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> flags_o[FL_ZF] == ($past(result_o) == '0));  // R6

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> flags_o[FL_SF] == ($past(word_i) ? $past(result_o[DW-1]) : $past(result_o[HW-1])));  // R7

endmodule

// File: tb/sim_bw_alu.sv
module sim_bw_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        flag_we_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [2:0]  ctrl_i = '0;
  logic [15:0] result_o;
  logic [15:0] flags_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_ctrl = 3'b000;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  bw_alu u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick8(input int k);
    case (k)
      0: return 'h00; 1: return 'h01; 2: return 'h7F; 3: return 'h80;
      4: return 'hFF; 5: return 'hFE; 6: return 'h0F; 7: return 'h10;
      default: return (k * 29 + 3) & 'hFF;
    endcase
  endfunction

  function automatic int pick16(input int k);
    case (k)
      0: return 'h0000; 1: return 'h0001; 2: return 'h7FFF; 3: return 'h8000;
      4: return 'hFFFF; 5: return 'hFFFE; 6: return 'h00FF; 7: return 'h0100;
      default: return (k * 4099 + 777) & 'hFFFF;
    endcase
  endfunction

  // reference model: returns {of,sf,zf,af,pf,cf,result[15:0]}
  function automatic logic [21:0] model(input int op, input bit wd, input int a, input int b, input bit cin);
    int lim, am, bm, sa, sb, full, sfull, r, ones, cu;
    bit cf, af, of, pf, zf, sf;
    lim = wd ? 65536 : 256;
    am = a % lim; bm = b % lim;
    sa = (am >= lim / 2) ? am - lim : am;
    sb = (bm >= lim / 2) ? bm - lim : bm;
    cf = 0; af = 0; of = 0; r = 0;
    cu = (op == 1 || op == 3) ? int'(cin) : 0;
    case (op)
      0, 1: begin
        full = am + bm + cu; cf = full >= lim; r = full % lim;
        af = ((am % 16) + (bm % 16) + cu) >= 16;
        sfull = sa + sb + cu; of = (sfull >= lim / 2) || (sfull < -(lim / 2));
      end
      2, 3: begin
        full = am - bm - cu; cf = full < 0; r = (full < 0) ? full + lim : full;
        af = (am % 16) < ((bm % 16) + cu);
        sfull = sa - sb - cu; of = (sfull >= lim / 2) || (sfull < -(lim / 2));
      end
      4: r = am & bm;
      5: r = am | bm;
      6: r = am ^ bm;
      default: r = bm;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    pf = (ones % 2) == 0;
    zf = r == 0;
    sf = r >= lim / 2;
    return {of, sf, zf, af, pf, cf, r[15:0]};
  endfunction

  task automatic drive(input int op, input bit wd, input int a, input int b, input bit we);
    @(negedge clk);
    op_i = op[2:0]; word_i = wd; a_i = a[15:0]; b_i = b[15:0]; flag_we_i = we;
  endtask

  task automatic set_cf(input bit v);
    drive(v ? 2 : 0, 1'b0, 0, v ? 1 : 0, 1'b1);
    @(posedge clk); #1;
    check("R3 carry preload", int'(flags_o[0]), int'(v));
  endtask

  task automatic run_op(input int op, input bit wd, input int a, input int b, input bit cin);
    logic [21:0] e;
    e = model(op, wd, a, b, cin);
    drive(op, wd, a, b, 1'b1);
    #1;
    check("R2 result", int'(result_o), int'(e[15:0]));
    @(posedge clk); #1;
    check("R3 carry", int'(flags_o[0]), int'(e[16]));
    check("R4 parity", int'(flags_o[2]), int'(e[17]));
    check("R5 half-carry", int'(flags_o[4]), int'(e[18]));
    check("R6 zero", int'(flags_o[6]), int'(e[19]));
    check("R7 sign", int'(flags_o[7]), int'(e[20]));
    check("R8 overflow", int'(flags_o[11]), int'(e[21]));
    check("R1 reserved bits", int'(flags_o & 16'hF02A), 0);
    check("R11 control bits", int'(flags_o[10:8]), int'(exp_ctrl));
    if (op >= 4) check("R9 cleared carry/half/overflow", int'({flags_o[11], flags_o[4], flags_o[0]}), 0);
  endtask

  initial begin : watchdog
    int cyc;
    for (cyc = 0; cyc < 190000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset flags", int'(flags_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // control load, then verify results leave it alone
    @(negedge clk); ctrl_i = 3'b101; ctrl_we_i = 1'b1;
    @(posedge clk); #1;
    exp_ctrl = 3'b101;
    check("R11 trap bit", int'(flags_o[8]), 1);
    check("R11 int-enable bit", int'(flags_o[9]), 0);
    check("R11 direction bit", int'(flags_o[10]), 1);
    @(negedge clk); ctrl_we_i = 1'b0; ctrl_i = 3'b010;

    // sweeps over both widths, all ops, both stored-carry values
    for (int wd = 0; wd < 2; wd++)
      for (int op = 0; op < 8; op++)
        for (int c = 0; c < 2; c++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
              int a, b;
              a = wd ? pick16(i) : pick8(i);
              b = wd ? pick16(j) : pick8(j);
              if (!wd && (i + j) % 3 == 0) begin
                a = a | 'hA500; b = b | 'h5A00;  // upper byte noise, ignored in byte mode
              end
              set_cf(c[0]);
              run_op(op, wd[0], a, b, c[0]);
            end

    // status write disabled: flags hold, result still computed
    set_cf(1'b1);
    held = flags_o;
    drive(0, 1'b0, 0, 0, 1'b0);
    #1;
    check("R10 result without update", int'(result_o), 0);
    @(posedge clk); #1;
    check("R10 flags held", int'(flags_o), int'(held));

    // control load together with status update
    @(negedge clk); ctrl_i = 3'b010; ctrl_we_i = 1'b1; op_i = 3'd4; word_i = 1'b1;
    a_i = 16'h0F0F; b_i = 16'hF0F0; flag_we_i = 1'b1;
    @(posedge clk); #1;
    exp_ctrl = 3'b010;
    check("R11 simultaneous load", int'(flags_o[10:8]), 2);
    check("R6 zero after AND", int'(flags_o[6]), 1);
    @(negedge clk); ctrl_we_i = 1'b0;

    // byte add carries out of bit 7 but not into bit 8
    run_op(0, 1'b0, 'hFF, 'h01, 1'b0);
    check("R3 byte carry out of bit 7", int'(flags_o[0]), 1);
    run_op(0, 1'b1, 'h00FF, 'h0001, 1'b0);
    check("R3 word no carry", int'(flags_o[0]), 0);
    check("R4 parity low byte only", int'(flags_o[2]), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule